// File: doc/BRIEF.md
# Single-Wire LED Stream Encoder

This block turns pixel colour words into the pulse train that chains of addressable LEDs read over one data wire. A pixel is handed over on a valid/ready handshake. The block arranges its colour fields in the order the LEDs expect and sends every bit as a high phase followed by a low phase. The length of the high phase carries the bit value: a short high phase means 0 and a long one means 1. Pixels of one frame follow each other with no idle time between them. After the last pixel of a frame, or when the reset request is pulsed, the line is held low long enough for the LEDs to latch what they received.

Bit timing is built from a fixed number of quanta per bit, set by a parameter (three or four). The quantum length in clocks, the number of high quanta for each bit value, the length of the latch period, the colour order and the pixel length (24 or 32 bits) are runtime inputs. A 125 MHz clock with a 38-cycle quantum and four quanta gives a bit time of about 1.2 µs.

Top module: `led_stream_enc`

## Requirements
- R1: After reset and while idle, `dout` is low and `pix_ready` is high, provided no reset request is pending.
- R2: A bit lasts QUANTA quanta of `cfg_qlen` clocks each, and a `cfg_qlen` of 0 behaves as 1. The line is high for the first `cfg_hi1` quanta when the bit is 1, or for the first `cfg_hi0` quanta when it is 0, and low for the rest of the bit. Both high counts must lie between 1 and QUANTA-1.
- R3: Components are 8 bits and go out MSB first. The colour order is set by `cfg_order`: 0 GRB, 1 RGB, 2 BRG, 3 BGR, 4 GBR, 5 RBG. The codes 6 and 7 behave as 0.
- R4: When `cfg_rgbw` is 1, a pixel is 32 bits long and the W byte follows the three ordered colour bytes. When `cfg_rgbw` is 0, a pixel is 24 bits long.
- R5: `pix_data` holds R in bits 31:24, G in 23:16, B in 15:8 and W in 7:0. A word is accepted on a clock where `pix_valid` and `pix_ready` are both high, and its first bit starts on the next clock.
- R6: While bits are being sent, `pix_ready` is high only on the final clock of a pixel's final bit. A pixel accepted on that clock starts with no gap.
- R7: After a pixel marked with `pix_last`, the line is held low for `cfg_rst_len` clocks, starting right after the final bit. `pix_ready` stays low during this time and goes high when it ends.
- R8: A pulse on `rst_req` drops `pix_ready` on the next clock. If the block is idle, a low period of `cfg_rst_len` clocks then follows. If a pixel is being sent, the low period follows that pixel.
- R9: After a pixel not marked as last, with no request pending, the block goes idle with the line low and `pix_ready` high. No low period is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_qlen | input | QLW | Quantum length in clocks (0 behaves as 1) |
| cfg_hi0 | input | $clog2(QUANTA+1) | High quanta for a 0 bit |
| cfg_hi1 | input | $clog2(QUANTA+1) | High quanta for a 1 bit |
| cfg_order | input | 3 | Colour order code |
| cfg_rgbw | input | 1 | 1 selects 32-bit pixels with W |
| cfg_rst_len | input | RLW | Latch low period in clocks (0 behaves as 1) |
| pix_valid | input | 1 | Pixel word offered |
| pix_data | input | 32 | Pixel word {R,G,B,W} |
| pix_last | input | 1 | Offered pixel ends the frame |
| pix_ready | output | 1 | Pixel word taken this clock when valid |
| rst_req | input | 1 | Request a latch low period |
| dout | output | 1 | Serial LED line |

## Verification
A fault in the quantum or bit counters changes the high count of a bit or shortens a bit. This shows on `dout` within the bit where it happens, and the decoded word then no longer matches. A wrong shift or reorder shows as a wrong decoded word when the pixel ends. A wrong sequencer state shows as `pix_ready` high in the middle of a pixel, as a gap between back-to-back pixels, or as a low period of the wrong length, all within one bit time or one low period.

// File: rtl/led_stream_enc_pkg.sv
package led_stream_enc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BIT  = 2'd1,
        ST_GAP  = 2'd2
    } enc_state_t;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
        logic [7:0] w;
    } pixel_t;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned BCNT_W   = 6;
    localparam int unsigned BITS_RGB = 24;
    localparam int unsigned BITS_RGBW = 32;

    // Arrange colour bytes in wire order, MSB-aligned; W trails when enabled.
    function automatic logic [WORD_W-1:0] arrange(pixel_t px, logic [2:0] ord, logic with_w);
        logic [23:0] tri_c;
        case (ord)
            3'd1:    tri_c = {px.r, px.g, px.b};
            3'd2:    tri_c = {px.b, px.r, px.g};
            3'd3:    tri_c = {px.b, px.g, px.r};
            3'd4:    tri_c = {px.g, px.b, px.r};
            3'd5:    tri_c = {px.r, px.b, px.g};
            default: tri_c = {px.g, px.r, px.b};
        endcase
        return {tri_c, (with_w ? px.w : 8'h00)};
    endfunction

endpackage

// File: rtl/led_bit_timer.sv
module led_bit_timer #(
    parameter int unsigned QUANTA = 4,
    parameter int unsigned QLW    = 8,
    localparam int unsigned QIW   = (QUANTA > 1) ? $clog2(QUANTA) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [QLW-1:0] qlen,
    output logic [QIW-1:0] qidx,
    output logic           bit_end
);
    localparam logic [QIW-1:0] QLAST = QIW'(QUANTA - 1);

    logic [QLW-1:0] qcnt;
    logic [QLW-1:0] qmax;
    logic           q_end;

    assign qmax    = (qlen == '0) ? '0 : qlen - 1'b1;
    assign q_end   = run && (qcnt == qmax);
    assign bit_end = q_end && (qidx == QLAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            qcnt <= '0;
            qidx <= '0;
        end else if (q_end) begin
            qcnt <= '0;
            qidx <= (qidx == QLAST) ? '0 : qidx + 1'b1;
        end else begin
            qcnt <= qcnt + 1'b1;
        end
    end
endmodule

// File: rtl/led_pix_shreg.sv
module led_pix_shreg
    import led_stream_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              wide,
    input  logic              shift,
    output logic              msb,
    output logic              last_bit
);
    logic [WORD_W-1:0] sr;
    logic [BCNT_W-1:0] bcnt;
    logic              wide_q;

    assign msb      = sr[WORD_W-1];
    assign last_bit = (bcnt == (wide_q ? BCNT_W'(BITS_RGBW - 1) : BCNT_W'(BITS_RGB - 1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '0;
            bcnt   <= '0;
            wide_q <= 1'b0;
        end else if (load) begin
            sr     <= word;
            bcnt   <= '0;
            wide_q <= wide;
        end else if (shift) begin
            sr     <= {sr[WORD_W-2:0], 1'b0};
            bcnt   <= bcnt + 1'b1;
        end
    end
endmodule

// File: rtl/led_gap_timer.sv
module led_gap_timer #(
    parameter int unsigned RLW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [RLW-1:0] len,
    output logic           done
);
    logic [RLW-1:0] cnt;
    logic [RLW-1:0] lmax;

    assign lmax = (len == '0) ? '0 : len - 1'b1;
    assign done = run && (cnt == lmax);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/led_stream_enc.sv
module led_stream_enc
    import led_stream_enc_pkg::*;
#(
    parameter int unsigned QUANTA = 4,
    parameter int unsigned QLW    = 8,
    parameter int unsigned RLW    = 16,
    localparam int unsigned HCW   = $clog2(QUANTA + 1),
    localparam int unsigned QIW   = (QUANTA > 1) ? $clog2(QUANTA) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [QLW-1:0] cfg_qlen,
    input  logic [HCW-1:0] cfg_hi0,
    input  logic [HCW-1:0] cfg_hi1,
    input  logic [2:0]     cfg_order,
    input  logic           cfg_rgbw,
    input  logic [RLW-1:0] cfg_rst_len,
    input  logic           pix_valid,
    input  logic [31:0]    pix_data,
    input  logic           pix_last,
    output logic           pix_ready,
    input  logic           rst_req,
    output logic           dout
);
    enc_state_t     st_q, st_d;
    logic           pend_q, last_q;
    logic [QIW-1:0] qidx;
    logic           bit_end, last_bit, msb, gap_done;
    logic           pix_end, accept, enter_gap;
    logic [HCW-1:0] hi_now;

    led_bit_timer #(.QUANTA(QUANTA), .QLW(QLW)) u_timer (
        .clk(clk), .rst(rst), .run(st_q == ST_BIT), .qlen(cfg_qlen),
        .qidx(qidx), .bit_end(bit_end)
    );

    led_pix_shreg u_shreg (
        .clk(clk), .rst(rst), .load(accept),
        .word(arrange(pixel_t'(pix_data), cfg_order, cfg_rgbw)),
        .wide(cfg_rgbw), .shift(bit_end && !last_bit),
        .msb(msb), .last_bit(last_bit)
    );

    led_gap_timer #(.RLW(RLW)) u_gap (
        .clk(clk), .rst(rst), .run(st_q == ST_GAP), .len(cfg_rst_len),
        .done(gap_done)
    );

    assign pix_end   = (st_q == ST_BIT) && bit_end && last_bit;
    assign pix_ready = !pend_q && ((st_q == ST_IDLE) || (pix_end && !last_q));
    assign accept    = pix_valid && pix_ready;
    assign hi_now    = msb ? cfg_hi1 : cfg_hi0;
    assign dout      = (st_q == ST_BIT) && (HCW'(qidx) < hi_now);

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: begin
                if (pend_q)      st_d = ST_GAP;
                else if (accept) st_d = ST_BIT;
            end
            ST_BIT: begin
                if (pix_end) begin
                    if (accept)                 st_d = ST_BIT;
                    else if (last_q || pend_q)  st_d = ST_GAP;
                    else                        st_d = ST_IDLE;
                end
            end
            ST_GAP:  if (gap_done) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign enter_gap = (st_d == ST_GAP) && (st_q != ST_GAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pend_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= enter_gap ? 1'b0 : (pend_q || rst_req);
            if (accept) last_q <= pix_last;
        end
    end
endmodule

// File: rtl/led_stream_enc_chk.sv
module led_stream_enc_chk
    import led_stream_enc_pkg::*;
#(
    parameter int unsigned QUANTA = 4,
    localparam int unsigned QIW   = (QUANTA > 1) ? $clog2(QUANTA) : 1
) (
    input logic           clk,
    input logic           rst,
    input logic           dout,
    input logic           pix_ready,
    input logic           pix_valid,
    input enc_state_t     st,
    input logic [QIW-1:0] qidx,
    input logic           bit_end,
    input logic           last_bit
);
    localparam logic [QIW-1:0] QLAST = QIW'(QUANTA - 1);

    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !dout); // R1

    AST_BIT_HEAD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BIT && qidx == '0) |-> dout); // R2

    AST_BIT_TAIL_LOW: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BIT && qidx == QLAST) |-> !dout); // R2

    AST_READY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BIT && pix_ready) |-> (bit_end && last_bit)); // R6

    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BIT && pix_valid && pix_ready) |=> (st == ST_BIT && qidx == '0)); // R6

    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GAP) |-> (!dout && !pix_ready)); // R7
endmodule

bind led_stream_enc led_stream_enc_chk #(.QUANTA(QUANTA)) u_chk (
    .clk(clk), .rst(rst), .dout(dout), .pix_ready(pix_ready),
    .pix_valid(pix_valid), .st(st_q), .qidx(qidx),
    .bit_end(bit_end), .last_bit(last_bit)
);

// File: tb/led_stream_enc_test.sv
module led_stream_enc_test;
    localparam int Q = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_qlen = 8'd2;
    logic [2:0]  cfg_hi0 = 3'd1, cfg_hi1 = 3'd2;
    logic [2:0]  cfg_order = 3'd0;
    logic        cfg_rgbw = 1'b0;
    logic [15:0] cfg_rst_len = 16'd10;
    logic        pix_valid = 1'b0, pix_last = 1'b0, rst_req = 1'b0;
    logic [31:0] pix_data = '0;
    logic        pix_ready, dout;

    int checks = 0, failures = 0;

    always #4 clk = ~clk;

    led_stream_enc #(.QUANTA(Q)) uut (
        .clk(clk), .rst(rst), .cfg_qlen(cfg_qlen), .cfg_hi0(cfg_hi0),
        .cfg_hi1(cfg_hi1), .cfg_order(cfg_order), .cfg_rgbw(cfg_rgbw),
        .cfg_rst_len(cfg_rst_len), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_last(pix_last), .pix_ready(pix_ready), .rst_req(rst_req), .dout(dout)
    );

    typedef struct packed {
        logic [2:0]  ord;
        logic        rgbw;
        logic [31:0] data;
        logic [7:0]  qlen;
        logic [2:0]  hi0;
        logic [2:0]  hi1;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 32'h12A53C00, 8'd2, 3'd1, 3'd2, 32'h00A5123C},
        '{3'd1, 1'b0, 32'h8001FF00, 8'd3, 3'd1, 3'd3, 32'h008001FF},
        '{3'd2, 1'b0, 32'h11223300, 8'd1, 3'd1, 3'd2, 32'h00331122},
        '{3'd3, 1'b0, 32'h11223300, 8'd0, 3'd1, 3'd3, 32'h00332211},
        '{3'd4, 1'b0, 32'h11223300, 8'd2, 3'd1, 3'd2, 32'h00223311},
        '{3'd5, 1'b0, 32'h11223300, 8'd2, 3'd2, 3'd3, 32'h00113322},
        '{3'd0, 1'b1, 32'h112233C4, 8'd2, 3'd1, 3'd2, 32'h221133C4},
        '{3'd7, 1'b0, 32'hF00F5500, 8'd1, 3'd1, 3'd2, 32'h000FF055}
    };

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Samples dout and pix_ready once per clock from the first bit cycle to
    // the last, decoding bits from the high time of each bit.
    task automatic capture(input int nb, input int qraw, input int hi0, input int hi1,
                           input logic ready_end, input string req,
                           output logic [31:0] word);
        int  ql = (qraw == 0) ? 1 : qraw;
        int  shape_bad = 0, ready_bad = 0;
        word = '0;
        for (int b = 0; b < nb; b++) begin
            int   hic = 0;
            logic seen_low = 1'b0;
            for (int c = 0; c < Q * ql; c++) begin
                logic fin = (b == nb - 1) && (c == Q * ql - 1);
                if (dout) begin
                    if (seen_low) shape_bad++;
                    hic++;
                end else seen_low = 1'b1;
                if (fin) begin
                    if (pix_ready !== ready_end) ready_bad++;
                end else if (pix_ready !== 1'b0) ready_bad++;
                if (!fin) @(negedge clk);
            end
            if (hic == hi1 * ql)      word = {word[30:0], 1'b1};
            else if (hic == hi0 * ql) word = {word[30:0], 1'b0};
            else begin
                shape_bad++;
                word = {word[30:0], 1'b0};
            end
        end
        check(shape_bad == 0, "R2", "bit shape errors", shape_bad, 0);
        check(ready_bad == 0, "R6", "ready outside boundary", ready_bad, 0);
    endtask

    task automatic gap_check(input int len, input string req);
        int bad = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pix_ready !== 1'b0 || dout !== 1'b0) bad++;
        end
        check(bad == 0, req, "line/ready during low period", bad, 0);
        @(negedge clk);
        check(pix_ready === 1'b1 && dout === 1'b0, req, "idle after low period",
              {pix_ready, dout}, 2'b10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pix_ready === 1'b1 && dout === 1'b0, "R1", "reset state",
              {pix_ready, dout}, 2'b10);

        // Table walk: one framed pixel each (R3, R4, R5, R7)
        for (int i = 0; i < NV; i++) begin
            cfg_order = VECS[i].ord;  cfg_rgbw = VECS[i].rgbw;
            cfg_qlen  = VECS[i].qlen; cfg_hi0  = VECS[i].hi0; cfg_hi1 = VECS[i].hi1;
            cfg_rst_len = 16'd10;
            pix_data = VECS[i].data; pix_last = 1'b1; pix_valid = 1'b1;
            @(negedge clk);
            pix_valid = 1'b0;
            capture(VECS[i].rgbw ? 32 : 24, VECS[i].qlen, VECS[i].hi0, VECS[i].hi1,
                    1'b0, "R3", got);
            check(got === VECS[i].exp, VECS[i].rgbw ? "R4" : "R3", "wire word", got, VECS[i].exp);
            gap_check(10, "R7");
        end

        // Back-to-back pixels with no gap (R6), then the frame end (R7)
        cfg_order = 3'd0; cfg_rgbw = 1'b0; cfg_qlen = 8'd2; cfg_hi0 = 3'd1; cfg_hi1 = 3'd2;
        cfg_rst_len = 16'd5;
        pix_data = 32'h12A53C00; pix_last = 1'b0; pix_valid = 1'b1;
        @(negedge clk);
        pix_data = 32'h8001FF00; pix_last = 1'b1;
        capture(24, 2, 1, 2, 1'b1, "R6", got);
        check(got === 32'h00A5123C, "R6", "first back-to-back word", got, 32'h00A5123C);
        @(negedge clk);
        pix_valid = 1'b0;
        capture(24, 2, 1, 2, 1'b0, "R6", got);
        check(got === 32'h000180FF, "R6", "second back-to-back word", got, 32'h000180FF);
        gap_check(5, "R7");

        // Pixel not marked last goes straight to idle (R9)
        pix_data = 32'hFF000000; pix_last = 1'b0; pix_valid = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        capture(24, 2, 1, 2, 1'b1, "R9", got);
        check(got === 32'h0000FF00, "R9", "unframed word", got, 32'h0000FF00);
        @(negedge clk);
        check(pix_ready === 1'b1 && dout === 1'b0, "R9", "idle without low period",
              {pix_ready, dout}, 2'b10);

        // Reset request while idle (R8)
        cfg_rst_len = 16'd3;
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        check(pix_ready === 1'b0, "R8", "ready drops after request", pix_ready, 0);
        gap_check(3, "R8");

        // Low period length of zero behaves as one clock (R7)
        cfg_rst_len = 16'd0;
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        gap_check(1, "R7");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule